// File: doc/BRIEF.md
# Sign-Magnitude Redundant Borrow-Save Subtracter

This block subtracts an ordinary unsigned binary operand from a redundant signed-digit operand and returns the difference in the same redundant form. Every redundant digit takes a value in {-1, 0, +1}. Each digit is carried as two bits: a sign bit and a magnitude bit. No borrow ripples across the word. Each result digit depends only on its own position and on the position just below it. The block can therefore sit in the loop of a recursive datapath, such as a multiplier or divider step, where the result feeds the next step's redundant input.

A mode input switches the block to addition. It does not complement the binary operand or insert a carry at the least significant digit. Instead it negates every redundant digit of the input, forms `-a - m`, and negates every digit of that difference to give `a + m`. Because the format is sign-magnitude, negating a digit only flips its sign bit. The word carries one extra digit above the top position, which holds the transfer out of the most significant stage.

The datapath is combinational. An optional output register, selected by a parameter, adds one cycle of latency. That register is cleared by a synchronous active-low reset.

Top module: `ssbs_subtracter`

## Requirements
- R1: Digit i of the redundant input has the value 0 when its magnitude bit is 0, and the value +1 or -1 when its magnitude bit is 1 (sign bit 0 gives +1, sign bit 1 gives -1). The operand value is the sum of digit_i·2^i. A digit with magnitude 0 and sign 1 counts as zero.
- R2: With `add_en` = 0, the result value Σ r_i·2^i + top·2^N equals A − M, where M is the unsigned value of `m_bin`.
- R3: With `add_en` = 1, the result value equals A + M.
- R4: Every output digit, including the top digit, is canonical: a digit whose magnitude bit is 0 has its sign bit at 0.
- R5: The top digit is 0 or −1 in subtract mode and 0 or +1 in add mode. When its magnitude bit is 1, its sign bit equals the inverse of `add_en`.
- R6: A change in input digit k (redundant or binary) can alter only result digits k and k+1. Digit N here means the top digit.
- R7: The result in add mode for input `a` equals the digit-wise negation of the result in subtract mode for `-a`. The magnitude bits are equal, and the sign bits are inverted wherever the magnitude is 1.
- R8: With the output register enabled, the outputs show the result of the inputs present at the previous rising clock edge. A rising edge with `rst_n` low clears every output bit to 0 on that edge.
- R9: The least significant result digit has magnitude `a_mag[0] XOR m_bin[0]`. It is never negative in subtract mode and never positive in add mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| add_en | input | 1 | 0 selects a − m, 1 selects a + m |
| a_sgn | input | N | Sign bits of the redundant operand digits |
| a_mag | input | N | Magnitude bits of the redundant operand digits |
| m_bin | input | N | Unsigned binary operand |
| r_sgn | output | N | Sign bits of the result digits |
| r_mag | output | N | Magnitude bits of the result digits |
| r_top_sgn | output | 1 | Sign bit of the top result digit (weight 2^N) |
| r_top_mag | output | 1 | Magnitude bit of the top result digit |

## Verification
On every cycle, the checker confirms that the numeric value of the result matches A − M or A + M for the inputs that produced it. It also confirms that zero digits are canonical, that the top digit has the right sign for the mode, that the lowest digit follows its operand bits, and that reset clears the outputs. Two properties relate two separate evaluations and so cannot be seen in any single cycle: that a disturbance stays within two digit positions, and that add mode mirrors subtract mode on the negated operand. The bench's paired scenarios show these, together with the one-cycle latency of the register.

// File: rtl/ssbs_pkg.sv
// Shared types and helpers for the sign-magnitude borrow-save subtracter.
// Assumes a digit value is 0 whenever its magnitude bit is 0.
package ssbs_pkg;

    // One redundant digit: sign bit and magnitude bit.
    typedef struct packed {
        logic sgn;
        logic mag;
    } sd_t;

    // Conditional negation that also forces zero digits to a positive sign.
    function automatic sd_t sd_negate(input sd_t x, input logic en);
        sd_t y;
        y.mag = x.mag;
        y.sgn = (x.sgn ^ en) & x.mag;
        return y;
    endfunction

endpackage

// File: rtl/ssbs_lower.sv
// Lower stage of one position: splits (a_i - m_i) into -2*t_out + d.
// Assumes a_i is in {-1,0,+1} and m_i in {0,1}; neg flips a_i's sign first.
module ssbs_lower (
    input  logic a_sgn,
    input  logic a_mag,
    input  logic m_bit,
    input  logic neg,
    output logic t_out,
    output logic d
);
    logic eff_sgn;

    // Form the transfer and the residue digit for this position.
    always_comb begin
        eff_sgn = a_sgn ^ neg;
        t_out   = a_mag ? eff_sgn : m_bit;
        d       = a_mag ^ m_bit;
    end
endmodule

// File: rtl/ssbs_upper.sv
// Upper stage of one position: s = d - t_in, then optional negation.
// Assumes d and t_in are each in {0,1}; the output is canonical.
module ssbs_upper
    import ssbs_pkg::*;
(
    input  logic d,
    input  logic t_in,
    input  logic neg,
    output sd_t  s
);
    sd_t raw;

    // Combine the residue with the incoming transfer and apply the mode.
    always_comb begin
        raw.mag = d ^ t_in;
        raw.sgn = t_in & ~d;
        s       = sd_negate(raw, neg);
    end
endmodule

// File: rtl/ssbs_outstage.sv
// Output stage: either a plain wire or a register with synchronous
// active-low clear, chosen by OUT_REG. Assumes W >= 1.
module ssbs_outstage #(
    parameter int W       = 18,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (OUT_REG) begin : g_reg
            logic [W-1:0] q;
            // Capture the result on each rising edge, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= din;
            end
            assign dout = q;
        end else begin : g_wire
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/ssbs_subtracter.sv
// N-digit sign-magnitude borrow-save subtracter with an add mode.
// Subtract: r = a - m. Add: r = -((-a) - m) = a + m, with digit negation
// done by sign flips only. Transfer into digit 0 is zero; the transfer
// out of digit N-1 appears as the top digit (weight 2^N).
module ssbs_subtracter
    import ssbs_pkg::*;
#(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         add_en,
    input  logic [N-1:0] a_sgn,
    input  logic [N-1:0] a_mag,
    input  logic [N-1:0] m_bin,
    output logic [N-1:0] r_sgn,
    output logic [N-1:0] r_mag,
    output logic         r_top_sgn,
    output logic         r_top_mag
);
    localparam int W = 2 * N + 2;

    logic [N:0]   t;
    logic [N-1:0] d;
    sd_t  [N-1:0] s;
    sd_t          top_raw;
    sd_t          top;
    logic [W-1:0] res_c;
    logic [W-1:0] res_q;

    assign t[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_pos
            ssbs_lower u_lo (
                .a_sgn (a_sgn[i]),
                .a_mag (a_mag[i]),
                .m_bit (m_bin[i]),
                .neg   (add_en),
                .t_out (t[i+1]),
                .d     (d[i])
            );
            ssbs_upper u_up (
                .d    (d[i]),
                .t_in (t[i]),
                .neg  (add_en),
                .s    (s[i])
            );
            assign res_c[i]     = s[i].sgn;
            assign res_c[N + i] = s[i].mag;
        end
    endgenerate

    // Top digit carries the value -t[N] before the mode negation.
    always_comb begin
        top_raw.mag = t[N];
        top_raw.sgn = t[N];
        top         = sd_negate(top_raw, add_en);
    end

    assign res_c[2*N]     = top.sgn;
    assign res_c[2*N + 1] = top.mag;

    ssbs_outstage #(.W(W), .OUT_REG(OUT_REG)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (res_c),
        .dout  (res_q)
    );

    assign r_sgn     = res_q[N-1:0];
    assign r_mag     = res_q[2*N-1:N];
    assign r_top_sgn = res_q[2*N];
    assign r_top_mag = res_q[2*N+1];
endmodule

// File: rtl/ssbs_checker.sv
// Assertion checker for ssbs_subtracter, attached by bind.
// Aligns inputs with the outputs they produced (one cycle when registered).
module ssbs_checker #(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         add_en,
    input logic [N-1:0] a_sgn,
    input logic [N-1:0] a_mag,
    input logic [N-1:0] m_bin,
    input logic [N-1:0] r_sgn,
    input logic [N-1:0] r_mag,
    input logic         r_top_sgn,
    input logic         r_top_mag
);
    logic         add_q;
    logic [N-1:0] sg_q, mg_q, m_q;
    logic         valid;

    generate
        if (OUT_REG) begin : g_align
            logic rst_seen;
            // Hold the inputs that the output register last captured.
            always_ff @(posedge clk) begin
                add_q    <= add_en;
                sg_q     <= a_sgn;
                mg_q     <= a_mag;
                m_q      <= m_bin;
                rst_seen <= rst_n;
            end
            assign valid = rst_seen;
        end else begin : g_direct
            assign add_q = add_en;
            assign sg_q  = a_sgn;
            assign mg_q  = a_mag;
            assign m_q   = m_bin;
            assign valid = 1'b1;
        end
    endgenerate

    function automatic longint rd_val(input logic [N-1:0] sg, input logic [N-1:0] mg);
        longint v = 0;
        for (int i = 0; i < N; i++)
            if (mg[i]) v += sg[i] ? -(longint'(1) <<< i) : (longint'(1) <<< i);
        return v;
    endfunction

    longint a_val, m_val, r_val;
    // Numeric values of the aligned operands and of the result.
    always_comb begin
        a_val = rd_val(sg_q, mg_q);
        m_val = longint'(m_q);
        r_val = rd_val(r_sgn, r_mag);
        if (r_top_mag) r_val += r_top_sgn ? -(longint'(1) <<< N) : (longint'(1) <<< N);
    end

    p_sub_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !add_q) |-> (r_val == a_val - m_val));

    p_add_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && add_q) |-> (r_val == a_val + m_val));

    p_canon_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_sgn & ~r_mag) == '0) && !(r_top_sgn && !r_top_mag));

    p_top_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && r_top_mag) |-> (r_top_sgn == !add_q));

    p_lsb_digit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((r_mag[0] == (mg_q[0] ^ m_q[0])) && (r_sgn[0] == (r_mag[0] & add_q))));

    generate
        if (OUT_REG) begin : g_rst_prop
            p_reset_clear_r8: assert property (@(posedge clk)
                !rst_n |=> (r_sgn == '0 && r_mag == '0 && !r_top_sgn && !r_top_mag));
        end
    endgenerate
endmodule

bind ssbs_subtracter ssbs_checker #(.N(N), .OUT_REG(OUT_REG)) u_ssbs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .add_en    (add_en),
    .a_sgn     (a_sgn),
    .a_mag     (a_mag),
    .m_bin     (m_bin),
    .r_sgn     (r_sgn),
    .r_mag     (r_mag),
    .r_top_sgn (r_top_sgn),
    .r_top_mag (r_top_mag)
);

// File: tb/tb_ssbs_subtracter.sv
// Self-checking bench for ssbs_subtracter (N = 8, registered output).
module tb_ssbs_subtracter;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         add_en = 1'b0;
    logic [N-1:0] a_sgn = '0, a_mag = '0, m_bin = '0;
    logic [N-1:0] r_sgn, r_mag;
    logic         r_top_sgn, r_top_mag;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ssbs_subtracter #(.N(N), .OUT_REG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .add_en(add_en),
        .a_sgn(a_sgn), .a_mag(a_mag), .m_bin(m_bin),
        .r_sgn(r_sgn), .r_mag(r_mag),
        .r_top_sgn(r_top_sgn), .r_top_mag(r_top_mag)
    );

    typedef struct packed {
        logic              add;
        logic [7:0]        sg;
        logic [7:0]        mg;
        logic [7:0]        m;
        logic signed [15:0] ex;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 8'h00, 8'h00,  16'sd0},
        '{1'b0, 8'h00, 8'h01, 8'h01,  16'sd0},
        '{1'b0, 8'h00, 8'h00, 8'hFF, -16'sd255},
        '{1'b1, 8'h00, 8'h00, 8'hFF,  16'sd255},
        '{1'b0, 8'h00, 8'hFF, 8'h00,  16'sd255},
        '{1'b0, 8'hFF, 8'hFF, 8'hFF, -16'sd510},
        '{1'b1, 8'hFF, 8'hFF, 8'hFF,  16'sd0},
        '{1'b1, 8'h00, 8'hFF, 8'hFF,  16'sd510},
        '{1'b0, 8'h05, 8'h0F, 8'h03,  16'sd2},
        '{1'b1, 8'h05, 8'h0F, 8'h03,  16'sd8},
        '{1'b0, 8'hFF, 8'h00, 8'h00,  16'sd0}
    };

    function automatic int dig(input logic s, input logic mg);
        return mg ? (s ? -1 : 1) : 0;
    endfunction

    function automatic int vec_val(input logic [N-1:0] s, input logic [N-1:0] mg);
        int v = 0;
        for (int i = 0; i < N; i++) v += dig(s[i], mg[i]) * (1 << i);
        return v;
    endfunction

    function automatic int res_val();
        return vec_val(r_sgn, r_mag) + dig(r_top_sgn, r_top_mag) * (1 << N);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register).
    task automatic apply(input logic ad, input logic [N-1:0] sg,
                         input logic [N-1:0] mg, input logic [N-1:0] m);
        @(negedge clk);
        add_en = ad; a_sgn = sg; a_mag = mg; m_bin = m;
        @(negedge clk);
    endtask

    task automatic shape_checks(input logic ad, input logic [N-1:0] mg, input logic [N-1:0] m);
        // R4: zero digits carry a clear sign bit
        check(((r_sgn & ~r_mag) == '0) && !(r_top_sgn && !r_top_mag), "R4",
              int'(r_sgn & ~r_mag), 0);
        // R5: top digit sign follows the mode
        check(!r_top_mag || (r_top_sgn == !ad), "R5", int'(r_top_sgn), int'(!ad));
        // R9: lowest digit magnitude and sign
        check((r_mag[0] == (mg[0] ^ m[0])) && (r_sgn[0] == (r_mag[0] & ad)), "R9",
              dig(r_sgn[0], r_mag[0]), (mg[0] ^ m[0]) ? (ad ? -1 : 1) : 0);
    endtask

    initial begin : watchdog
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] sg, mg, m, sg2, rs0, rm0;
        logic         ts0, tm0;
        int           ex, v0;

        // R8: reset clears outputs even with nonzero inputs present
        add_en = 1'b1; a_sgn = 8'h00; a_mag = 8'hFF; m_bin = 8'hFF;
        @(negedge clk); @(negedge clk);
        check(r_sgn == '0 && r_mag == '0 && !r_top_sgn && !r_top_mag, "R8 reset",
              int'({r_top_mag, r_top_sgn, r_mag, r_sgn}), 0);
        rst_n = 1'b1;

        // R1 R2 R3: vector table
        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].add, VECS[k].sg, VECS[k].mg, VECS[k].m);
            check(res_val() == int'(VECS[k].ex), VECS[k].add ? "R3 table" : "R2/R1 table",
                  res_val(), int'(VECS[k].ex));
            shape_checks(VECS[k].add, VECS[k].mg, VECS[k].m);
        end

        // R2 R3: random operands in both modes against integer arithmetic
        for (int k = 0; k < 400; k++) begin
            logic ad;
            ad = k[0];
            sg = 8'($urandom); mg = 8'($urandom); m = 8'($urandom);
            apply(ad, sg, mg, m);
            ex = ad ? vec_val(sg, mg) + int'(m) : vec_val(sg, mg) - int'(m);
            check(res_val() == ex, ad ? "R3 random" : "R2 random", res_val(), ex);
            shape_checks(ad, mg, m);
        end

        // R8: output holds until the next rising edge, then follows
        apply(1'b0, 8'h00, 8'h10, 8'h00);
        @(negedge clk);
        add_en = 1'b0; a_sgn = 8'h00; a_mag = 8'h00; m_bin = 8'h01;
        #1;
        check(res_val() == 16, "R8 latency hold", res_val(), 16);
        @(negedge clk);
        check(res_val() == -1, "R8 latency update", res_val(), -1);

        // R6: disturbing digit k touches only result digits k and k+1
        for (int k = 0; k < N; k++) begin
            sg = 8'($urandom); mg = 8'($urandom); m = 8'($urandom);
            apply(1'b0, sg, mg, m);
            rs0 = r_sgn; rm0 = r_mag; ts0 = r_top_sgn; tm0 = r_top_mag;
            m[k] = ~m[k];
            apply(1'b0, sg, mg, m);
            begin
                logic [N:0] keep, diff;
                keep = ~((9'b11) << k);
                diff = {(ts0 ^ r_top_sgn) | (tm0 ^ r_top_mag), (rs0 ^ r_sgn) | (rm0 ^ r_mag)};
                check((diff & keep) == '0, "R6 locality", int'(diff & keep), 0);
            end
        end

        // R7: add mode on a equals negation of subtract mode on -a
        for (int k = 0; k < 20; k++) begin
            sg = 8'($urandom); mg = 8'($urandom); m = 8'($urandom);
            sg2 = sg ^ 8'hFF;
            apply(1'b0, sg2, mg, m);
            rs0 = r_sgn; rm0 = r_mag; ts0 = r_top_sgn; tm0 = r_top_mag;
            v0 = res_val();
            apply(1'b1, sg, mg, m);
            check(r_mag == rm0 && r_top_mag == tm0 &&
                  r_sgn == ((rs0 ^ 8'hFF) & rm0) && r_top_sgn == (!ts0 && tm0),
                  "R7 mirror", res_val(), -v0);
        end

        // R8: reset in mid-run clears outputs on the next edge
        apply(1'b1, 8'h00, 8'hFF, 8'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(r_sgn == '0 && r_mag == '0 && !r_top_sgn && !r_top_mag, "R8 mid reset",
              res_val(), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule